// File: doc/BRIEF.md
# FIFO Level Threshold Request Generator

This block holds a transmit queue and a receive queue, each eight words of 32 bits. It watches how full each queue is and raises three request lines: one interrupt line and two DMA lines. Each of the three request channels has its own configuration word. The word enables a receive term and a transmit term and sets a separate 4-bit threshold for each term.

A receive term asks for service once enough words are waiting to be drained. A transmit term asks for service once the queue has emptied far enough to be refilled. A channel's output is the OR of its two terms. A status word gives software-visible copies of both queue levels and of the three request lines. Queue pushes and pops come from the surrounding logic.

Top module: `fifo_req_gen`

## Requirements
- R1: Each queue holds up to 8 words of 32 bits. A push to a full queue (level 8) with no pop in the same cycle is dropped, and the level stays at 8.
- R2: A pop from a non-empty queue returns the oldest stored word on the read-data output one cycle after the pop edge. A pop from an empty queue returns zero. Read data holds its value in cycles without a pop.
- R3: The levels stay within 0 to 8. A push and a pop in the same cycle are both accepted when the level is between 1 and 7. On a full queue only the pop is accepted. On an empty queue only the push is accepted and the pop returns zero.
- R4: The status word carries the interrupt request in bit 0, DMA request 1 in bit 1, DMA request 2 in bit 2, the receive level in bits 11:8 and the transmit level in bits 19:16. All other bits read zero.
- R5: Each configuration word uses bit 0 as the receive enable, bit 1 as the transmit enable, bits 11:8 as the receive threshold and bits 19:16 as the transmit threshold. All other bits have no effect.
- R6: The receive term of a channel is true when its receive enable is set and the receive level is greater than or equal to its receive threshold. A threshold of 0 makes the term always true.
- R7: The transmit term of a channel is true when its transmit enable is set and the transmit level is less than or equal to its transmit threshold.
- R8: Each request output is a register that holds the OR of the channel's two terms, evaluated on the levels that result from the same edge. It rises and falls on the edge that changes the level. A configuration change takes effect at the next edge.
- R9: The interrupt channel and the two DMA channels are evaluated independently. Each uses only its own configuration word.
- R10: A synchronous active-high reset empties both queues and clears the levels, the request outputs and both read-data outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Write a word into the transmit queue |
| tx_wdata | input | 32 | Word written into the transmit queue |
| tx_pop | input | 1 | Read a word from the transmit queue |
| tx_rdata | output | 32 | Word read from the transmit queue |
| rx_push | input | 1 | Write a word into the receive queue |
| rx_wdata | input | 32 | Word written into the receive queue |
| rx_pop | input | 1 | Read a word from the receive queue |
| rx_rdata | output | 32 | Word read from the receive queue |
| irq_cfg | input | 32 | Interrupt channel configuration |
| dma1_cfg | input | 32 | DMA channel 1 configuration |
| dma2_cfg | input | 32 | DMA channel 2 configuration |
| irq_req | output | 1 | Interrupt request |
| dma1_req | output | 1 | DMA request 1 |
| dma2_req | output | 1 | DMA request 2 |
| status | output | 32 | Levels and request flags |

## Verification
Level changes and request changes both become visible right after the edge that accepts a push or pop, because the requests are computed from the next-state levels. Popped data appears one edge after the pop, and a configuration change shows up in the requests one edge after it is applied. The bench's reference model advances on the same rising edge as the design. Every output is compared at the following falling edge, so each result is sampled exactly in the cycle it is due.

// File: rtl/frg_pkg.sv
package frg_pkg;
  // configuration word field positions (shared by all three channels)
  localparam int CFG_RX_EN_BIT  = 0;
  localparam int CFG_TX_EN_BIT  = 1;
  localparam int CFG_RX_THR_LSB = 8;
  localparam int CFG_TX_THR_LSB = 16;
  localparam int THR_W          = 4;
  // status word field positions
  localparam int ST_RX_LVL_LSB  = 8;
  localparam int ST_TX_LVL_LSB  = 16;
  localparam int LVL_FIELD_W    = 4;
  // channel order also gives the status bit of each request
  localparam int NUM_CHAN       = 3;
  localparam int CH_IRQ         = 0;
  localparam int CH_DMA1        = 1;
  localparam int CH_DMA2        = 2;
endpackage

// File: rtl/frg_fifo.sv
module frg_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              push,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic                              pop,
  output logic [DATA_W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]        level,
  output logic [$clog2(DEPTH+1)-1:0]        level_nxt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  // acceptance is decided on the level before this edge
  assign do_push = push && (level != FULL);
  assign do_pop  = pop  && (level != '0);

  always_comb begin
    level_nxt = level;
    if (do_push && !do_pop) level_nxt = level + LW'(1);
    else if (do_pop && !do_push) level_nxt = level - LW'(1);
  end

  // storage without reset so it can map onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop) begin
      rdata <= do_pop ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      level <= level_nxt;
    end
  end
endmodule

// File: rtl/frg_req_chan.sv
module frg_req_chan
  import frg_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   cfg,
  input  logic [LW-1:0] rx_level_nxt,
  input  logic [LW-1:0] tx_level_nxt,
  output logic          req
);
  logic             rx_en, tx_en, rx_hit, tx_hit;
  logic [THR_W-1:0] rx_thr, tx_thr;
  logic             unused_cfg_bits;

  assign rx_en  = cfg[CFG_RX_EN_BIT];
  assign tx_en  = cfg[CFG_TX_EN_BIT];
  assign rx_thr = cfg[CFG_RX_THR_LSB +: THR_W];
  assign tx_thr = cfg[CFG_TX_THR_LSB +: THR_W];
  assign unused_cfg_bits = ^{cfg[31:CFG_TX_THR_LSB+THR_W],
                             cfg[CFG_TX_THR_LSB-1:CFG_RX_THR_LSB+THR_W],
                             cfg[CFG_RX_THR_LSB-1:CFG_TX_EN_BIT+1]};

  // receive side wants draining when full enough, transmit side wants filling when low
  always_comb begin
    rx_hit = rx_en && (int'(rx_level_nxt) >= int'(rx_thr));
    tx_hit = tx_en && (int'(tx_level_nxt) <= int'(tx_thr));
  end

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= rx_hit || tx_hit;
  end
endmodule

// File: rtl/fifo_req_gen.sv
module fifo_req_gen
  import frg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic [31:0]       irq_cfg,
  input  logic [31:0]       dma1_cfg,
  input  logic [31:0]       dma2_cfg,
  output logic              irq_req,
  output logic              dma1_req,
  output logic              dma2_req,
  output logic [31:0]       status
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [LW-1:0]       tx_level, tx_level_nxt, rx_level, rx_level_nxt;
  logic [31:0]         cfg_arr [NUM_CHAN];
  logic [NUM_CHAN-1:0] req_vec;

  frg_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_q (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .level(tx_level), .level_nxt(tx_level_nxt));

  frg_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_q (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .level(rx_level), .level_nxt(rx_level_nxt));

  assign cfg_arr[CH_IRQ]  = irq_cfg;
  assign cfg_arr[CH_DMA1] = dma1_cfg;
  assign cfg_arr[CH_DMA2] = dma2_cfg;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    frg_req_chan #(.LW(LW)) chan_i (
      .clk(clk), .rst(rst), .cfg(cfg_arr[c]),
      .rx_level_nxt(rx_level_nxt), .tx_level_nxt(tx_level_nxt),
      .req(req_vec[c]));
  end

  assign irq_req  = req_vec[CH_IRQ];
  assign dma1_req = req_vec[CH_DMA1];
  assign dma2_req = req_vec[CH_DMA2];

  always_comb begin
    status = '0;
    status[NUM_CHAN-1:0] = req_vec;
    status[ST_RX_LVL_LSB +: LVL_FIELD_W] = LVL_FIELD_W'(rx_level);
    status[ST_TX_LVL_LSB +: LVL_FIELD_W] = LVL_FIELD_W'(tx_level);
  end
endmodule

// File: rtl/frg_checker.sv
module frg_checker (
  input logic        clk,
  input logic        rst,
  input logic        rx_push,
  input logic        rx_pop,
  input logic [31:0] rx_rdata,
  input logic [31:0] irq_cfg,
  input logic [31:0] dma2_cfg,
  input logic        irq_req,
  input logic        dma2_req,
  input logic [31:0] status
);
  logic [3:0] rxl, txl;
  logic       armed;
  assign rxl = status[11:8];
  assign txl = status[19:16];

  // armed once the previous cycle was outside reset
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  function automatic logic want(input logic [31:0] c, input logic [3:0] r, input logic [3:0] t);
    return (c[0] && (r >= c[11:8])) || (c[1] && (t <= c[19:16]));
  endfunction

  assert_level_range_R3: assert property (@(posedge clk) disable iff (rst)
    (rxl <= 4'd8) && (txl <= 4'd8));

  assert_full_drop_R1: assert property (@(posedge clk) disable iff (rst)
    (rxl == 4'd8 && rx_push && !rx_pop) |=> (rxl == 4'd8));

  assert_empty_pop_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rxl == 4'd0 && rx_pop) |=> (rx_rdata == 32'd0));

  assert_status_spare_R4: assert property (@(posedge clk) disable iff (rst)
    (status & 32'hFFF0_F0F8) == 32'd0);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (irq_req == want($past(irq_cfg), rxl, txl)));

  assert_dma2_own_cfg_R9: assert property (@(posedge clk) disable iff (rst)
    armed |-> (dma2_req == want($past(dma2_cfg), rxl, txl)));
endmodule

bind fifo_req_gen frg_checker chk_i (
  .clk(clk), .rst(rst), .rx_push(rx_push), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
  .irq_cfg(irq_cfg), .dma2_cfg(dma2_cfg), .irq_req(irq_req), .dma2_req(dma2_req),
  .status(status));

// File: tb/fifo_req_gen_tb_top.sv
`timescale 1ns/1ps
module fifo_req_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [31:0] tx_wdata = 0, rx_wdata = 0;
  logic [31:0] irq_cfg = 0, dma1_cfg = 0, dma2_cfg = 0;
  logic [31:0] tx_rdata, rx_rdata, status;
  logic        irq_req, dma1_req, dma2_req;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fifo_req_gen dut_i (
    .clk(clk), .rst(rst), .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .irq_cfg(irq_cfg), .dma1_cfg(dma1_cfg), .dma2_cfg(dma2_cfg),
    .irq_req(irq_req), .dma1_req(dma1_req), .dma2_req(dma2_req), .status(status));

  // ---------------- reference model ----------------
  logic [31:0] mq_rx[$], mq_tx[$];
  logic [31:0] m_rx_rd = 0, m_tx_rd = 0;
  logic        m_req[3] = '{0, 0, 0};

  function automatic logic term(input logic [31:0] c, input int r, input int t);
    return (c[0] && r >= int'(c[11:8])) || (c[1] && t <= int'(c[19:16]));
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] s = 0;
    s[0] = m_req[0]; s[1] = m_req[1]; s[2] = m_req[2];
    s[11:8]  = 4'(mq_rx.size());
    s[19:16] = 4'(mq_tx.size());
    return s;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mq_rx.delete(); mq_tx.delete();
      m_rx_rd = 0; m_tx_rd = 0;
      foreach (m_req[i]) m_req[i] = 0;
    end else begin
      bit rx_ok_push, tx_ok_push;
      rx_ok_push = rx_push && mq_rx.size() < 8;
      tx_ok_push = tx_push && mq_tx.size() < 8;
      if (rx_pop) m_rx_rd = (mq_rx.size() > 0) ? mq_rx.pop_front() : 32'd0;
      if (tx_pop) m_tx_rd = (mq_tx.size() > 0) ? mq_tx.pop_front() : 32'd0;
      if (rx_ok_push) mq_rx.push_back(rx_wdata);
      if (tx_ok_push) mq_tx.push_back(tx_wdata);
      m_req[0] = term(irq_cfg,  mq_rx.size(), mq_tx.size());
      m_req[1] = term(dma1_cfg, mq_rx.size(), mq_tx.size());
      m_req[2] = term(dma2_cfg, mq_rx.size(), mq_tx.size());
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (cyc >= 2 && !done) begin
      check("R2 rx read data", rx_rdata, m_rx_rd);
      check("R2 tx read data", tx_rdata, m_tx_rd);
      check("R4 status word", status, m_status());
      check("R8 irq request", {31'd0, irq_req}, {31'd0, m_req[0]});
      check("R9 dma1 request", {31'd0, dma1_req}, {31'd0, m_req[1]});
      check("R9 dma2 request", {31'd0, dma2_req}, {31'd0, m_req[2]});
    end
  end

  logic [31:0] word_ctr = 32'h1000_0000;

  task automatic step(input logic rpu, input logic rpo, input logic tpu, input logic tpo);
    rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo;
    rx_wdata = word_ctr; tx_wdata = ~word_ctr;
    word_ctr++;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10 status after reset", status, 32'd0);
    check("R10 rx data after reset", rx_rdata, 32'd0);

    // irq: rx thr 3 with junk in unused bits; dma1: tx thr 2; dma2: rx thr 8
    irq_cfg  = 32'h8000_0321 | 32'h0000_0300;
    irq_cfg  = 32'h8000_0321;
    dma1_cfg = 32'h0002_0002;
    dma2_cfg = 32'h0000_0801;
    step(0, 0, 0, 0);
    check("R7 dma1 tx term at level 0", {31'd0, dma1_req}, 32'd1);
    check("R6 irq below rx threshold", {31'd0, irq_req}, 32'd0);

    step(1, 0, 0, 0); step(1, 0, 0, 0);
    check("R6 irq at level 2", {31'd0, irq_req}, 32'd0);
    step(1, 0, 0, 0);
    check("R6 irq at level 3", {31'd0, irq_req}, 32'd1);
    check("R5 junk cfg bits ignored", {31'd0, irq_req}, 32'd1);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
    check("R9 dma2 at level 8", {31'd0, dma2_req}, 32'd1);
    check("R9 dma1 unaffected", {31'd0, dma1_req}, 32'd1);
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    check("R1 level holds at 8", {28'd0, status[11:8]}, 32'd8);

    step(1, 1, 0, 0);
    check("R3 full push+pop level", {28'd0, status[11:8]}, 32'd7);
    check("R3 oldest word out", rx_rdata, 32'h1000_0001);
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0);
    check("R2 pop of empty gives zero", rx_rdata, 32'd0);
    check("R8 dma2 fell", {31'd0, dma2_req}, 32'd0);
    step(1, 1, 0, 0);
    check("R3 empty push+pop level", {28'd0, status[11:8]}, 32'd1);

    step(0, 0, 1, 0); step(0, 0, 1, 0);
    check("R7 dma1 at tx level 2", {31'd0, dma1_req}, 32'd1);
    step(0, 0, 1, 0);
    check("R7 dma1 off at tx level 3", {31'd0, dma1_req}, 32'd0);
    step(0, 0, 0, 1);
    check("R8 dma1 back on same edge", {31'd0, dma1_req}, 32'd1);

    irq_cfg = 32'h0001_0002;  // tx only, thr 1; tx level is 2
    step(0, 0, 0, 0);
    check("R8 cfg change after one edge", {31'd0, irq_req}, 32'd0);

    // random traffic with configuration churn and occasional reset
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 39) == 0) begin
        irq_cfg = $urandom; dma1_cfg = $urandom; dma2_cfg = $urandom;
      end
      rst = ($urandom_range(0, 499) == 0);
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      if (rst) begin
        rst = 0;
        check("R10 status after mid-run reset", status, 32'd0);
      end
    end
    finish_run();
  end
endmodule